// File: doc/BRIEF.md
# Multi-Port Rule Prefetcher

The rule prefetcher reads a packet-classification ruleset out of a request/response memory and delivers it, one rule per handshake, to a matching engine that compares every rule against a batch of packet headers. The memory is reached through several independent ports. Each port has its own prefetch unit. A unit issues fixed-size aligned reads in ascending slot order, collects the multi-beat response, and splits it into two rules. A merge stage visits the units in turn so that the rules leave in global index order.

A matching pass begins when `pass_start` is seen while no pass is running. The rule count given with it fixes how many rules that pass delivers. Once a unit has requested every slot of the running pass, it continues into the next pass and requests up to a quarter of that pass's slots early, while the engine finishes its work. The next pass therefore has to keep at least that many slots. This bounds how far the ruleset may shrink between two passes. If the count is odd, the unused second rule of the last read is removed and is never delivered.

Top module: `rule_prefetch`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pass_active`, `rule_valid` and every `mem_req_valid` bit are low.
- R2: `pass_start` is accepted only while `pass_active` is low. On acceptance it samples `rule_count`, and `pass_active` is high from the next cycle. A `pass_start` given while a pass is running has no effect on the rules delivered.
- R3: Request slot s (rules 2s and 2s+1) is always issued on port s mod NUM_PORTS, at byte address BASE_ADDR + s*128, with the slots of each port in ascending order within a pass.
- R4: A response is eight 128-bit beats, and beat b fills bits [128b+127:128b]. Rule 2s is bits [511:0] of slot s's response and rule 2s+1 is bits [1023:512].
- R5: A pass of N rules delivers rules 0..N-1 in ascending order. `rule_idx` carries the index, and `rule_last` is high only on rule N-1.
- R6: When N is odd, the second rule of the last slot is discarded. No rule is delivered after `rule_last` until the next pass is accepted.
- R7: After every slot of a pass of N rules is requested, the units request slots 0..P-1 of the next pass before it starts, with P = floor(ceil(N/2)/4). Each port's buffer room still applies.
- R8: The next count N' must give ceil(N'/2) >= P. A pass that shrinks exactly to this limit, including one with an odd count, is delivered correctly from the early-fetched data.
- R9: When `rule_ready` is low, `rule_valid` and `rule_data` hold. When `mem_req_ready` is low, a pending request holds its valid and address.
- R10: On each port, requests in flight plus responses not yet fully consumed never exceed FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pass_start | input | 1 | Request to begin a matching pass |
| rule_count | input | CNT_W | Rules in the pass, sampled on acceptance |
| pass_active | output | 1 | A pass is being delivered |
| mem_req_valid | output | NUM_PORTS | Read request valid per port |
| mem_req_ready | input | NUM_PORTS | Memory accepts the request per port |
| mem_req_addr | output | NUM_PORTS*ADDR_W | Byte address per port |
| mem_rsp_valid | input | NUM_PORTS | Response beat valid per port |
| mem_rsp_data | input | NUM_PORTS*BEAT_W | Response beat per port |
| rule_valid | output | 1 | Output rule valid |
| rule_ready | input | 1 | Matching engine takes the rule |
| rule_data | output | RULE_W | Rule contents |
| rule_idx | output | CNT_W | Index of the rule within the pass |
| rule_last | output | 1 | Final rule of the pass |

## Verification
The bench goes after the pass boundary in several forms.

Pass pairs that shrink exactly to the early-fetch limit test whether the early reads are credited to the new pass. A design that restarts its cursors would repeat rules, and one that drops the early data would lose them. Odd counts, including a count of one served entirely from the early-fetched slot, show whether a design leaks the surplus rule into the stream or leaves it in the buffer to shift the next pass.

Long output stalls combined with random memory backpressure test the buffer limit and the hold behaviour. A design with wrong credit accounting would overrun a buffer, and the cumulative request count checked at every pass start exposes any error in the early fetch amount.

// File: rtl/rpf_pkg.sv
// Shared types for the rule prefetcher.
package rpf_pkg;

    // Merge stage state: waiting for a pass, delivering rules, removing the surplus odd rule.
    typedef enum logic [1:0] {
        MRG_IDLE = 2'd0,
        MRG_RUN  = 2'd1,
        MRG_DROP = 2'd2
    } mrg_state_e;

endpackage

// File: rtl/rpf_unit.sv
// One prefetch unit, serving one memory port.
// It walks the request slots UNIT_ID, UNIT_ID+NUM_PORTS, ... in ascending order.
// In normal mode it stops below slots_cur. In early mode (the next pass) it stops below slots_pf.
// It assembles BEATS response beats into one response word and offers that word as two rules.
// Assumptions: responses arrive in request order, NUM_PORTS and FIFO_DEPTH are powers of two (>= 2),
// and the merge stage pops rules in index order.
module rpf_unit #(
    parameter int                UNIT_ID    = 0,
    parameter int                NUM_PORTS  = 8,
    parameter int                BEAT_W     = 128,
    parameter int                BEATS      = 8,
    parameter int                ADDR_W     = 32,
    parameter int                CNT_W      = 21,
    parameter int                FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pass_go,
    input  logic [CNT_W-1:0]          slots_cur,
    input  logic [CNT_W-1:0]          slots_pf,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [ADDR_W-1:0]         req_addr,
    input  logic                      rsp_valid,
    input  logic [BEAT_W-1:0]         rsp_data,
    input  logic                      pop,
    output logic                      head_valid,
    output logic [BEAT_W*BEATS/2-1:0] head_rule
);
    localparam int RESP_W = BEAT_W * BEATS;
    localparam int RULE_W = RESP_W / 2;
    localparam int PW     = $clog2(NUM_PORTS);
    localparam int OFS    = $clog2(RESP_W / 8);
    localparam int BW     = $clog2(BEATS);
    localparam int FW     = $clog2(FIFO_DEPTH + 1);
    localparam int PTR_W  = $clog2(FIFO_DEPTH);

    logic [CNT_W-1:0]         cursor;
    logic                     ahead;
    logic [CNT_W-1:0]         slot_idx;
    logic                     in_range;
    logic                     room;
    logic                     req_fire;
    logic [FW-1:0]            n_out;
    logic [FW-1:0]            n_buf;
    logic [BW-1:0]            beat_cnt;
    logic [RESP_W-BEAT_W-1:0] gather;
    logic                     rsp_done;
    logic                     half;
    logic [PTR_W-1:0]         wr_ptr;
    logic [PTR_W-1:0]         rd_ptr;
    logic [RESP_W-1:0]        store [FIFO_DEPTH];

    // Build the slot index and request address, and check for buffer room.
    always_comb begin
        slot_idx  = {cursor[CNT_W-PW-1:0], PW'(UNIT_ID)};
        in_range  = ahead ? (slot_idx < slots_pf) : (slot_idx < slots_cur);
        room      = ({1'b0, n_buf} + {1'b0, n_out}) < (FW + 1)'(FIFO_DEPTH);
        req_valid = in_range && room;
        req_addr  = BASE_ADDR + (ADDR_W'(slot_idx) << OFS);
        req_fire  = req_valid && req_ready;
        rsp_done  = rsp_valid && (beat_cnt == BW'(BEATS - 1));
    end

    // Move the slot cursor forward and switch into early mode for the next pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor <= '0;
            ahead  <= 1'b0;
        end else if (pass_go) begin
            ahead  <= 1'b0;
            cursor <= ahead ? cursor + CNT_W'(req_fire) : '0;
        end else if (req_fire) begin
            cursor <= cursor + 1'b1;
        end else if (!ahead && !in_range) begin
            ahead  <= 1'b1;
            cursor <= '0;
        end
    end

    // Count requests in flight and responses held in the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_out <= '0;
            n_buf <= '0;
        end else begin
            n_out <= n_out + FW'(req_fire) - FW'(rsp_done);
            n_buf <= n_buf + FW'(rsp_done) - FW'(pop && half);
        end
    end

    // Collect beats, filling the word from the top so that beat 0 ends up in the lowest bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= '0;
            gather   <= '0;
        end else if (rsp_valid) begin
            beat_cnt <= rsp_done ? '0 : beat_cnt + 1'b1;
            gather   <= {rsp_data, gather[RESP_W-BEAT_W-1:BEAT_W]};
        end
    end

    // Move the buffer pointers and the half selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            half   <= 1'b0;
        end else begin
            if (rsp_done) wr_ptr <= wr_ptr + 1'b1;
            if (pop) begin
                half <= !half;
                if (half) rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // Write each completed response word into the buffer.
    always_ff @(posedge clk) begin
        if (rsp_done) store[wr_ptr] <= {rsp_data, gather};
    end

    // Offer the rule at the head of the buffer.
    always_comb begin
        head_valid = (n_buf != '0);
        head_rule  = half ? store[rd_ptr][RESP_W-1:RULE_W] : store[rd_ptr][RULE_W-1:0];
    end
endmodule

// File: rtl/rpf_merge.sv
// Merge stage. It delivers the rules of one pass in global index order.
// Rule r comes from unit (r/2) mod NUM_PORTS, so the units are visited round-robin, two rules each.
// When the count is odd, it pops and discards the surplus second rule of the last slot after the pass.
// Assumption: NUM_PORTS is a power of two and at least 2.
module rpf_merge
    import rpf_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int RULE_W    = 512,
    parameter int CNT_W     = 21
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pass_go,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [NUM_PORTS-1:0]        head_valid,
    input  logic [NUM_PORTS*RULE_W-1:0] head_rule,
    output logic [NUM_PORTS-1:0]        pop,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [RULE_W-1:0]           out_rule,
    output logic [CNT_W-1:0]            out_idx,
    output logic                        out_last,
    output logic                        active
);
    localparam int PW = $clog2(NUM_PORTS);

    mrg_state_e     st;
    logic [CNT_W-1:0] r;
    logic [CNT_W-1:0] pick;
    logic [PW-1:0]    sel;
    logic             sel_valid;
    logic             fire;

    // Choose the unit that holds the rule wanted next.
    always_comb begin
        pick      = (st == MRG_DROP) ? r - 1'b1 : r;
        sel       = pick[PW:1];
        sel_valid = head_valid[sel];
        out_rule  = head_rule[sel*RULE_W +: RULE_W];
        out_valid = (st == MRG_RUN) && (r < cnt) && sel_valid;
        out_last  = (r == cnt - 1'b1);
        out_idx   = r;
        fire      = out_valid && out_ready;
        active    = (st != MRG_IDLE);
    end

    // Pop from the chosen unit when a rule is delivered or the surplus rule is removed.
    always_comb begin
        pop = '0;
        if (fire || (st == MRG_DROP && sel_valid)) pop[sel] = 1'b1;
    end

    // Step through the pass, then drop the surplus rule if needed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= MRG_IDLE;
            r  <= '0;
        end else begin
            case (st)
                MRG_IDLE: if (pass_go) begin
                    st <= MRG_RUN;
                    r  <= '0;
                end
                MRG_RUN: if (fire) begin
                    r <= r + 1'b1;
                    if (out_last) st <= cnt[0] ? MRG_DROP : MRG_IDLE;
                end else if (r >= cnt) begin
                    st <= MRG_IDLE;
                end
                MRG_DROP: if (sel_valid) st <= MRG_IDLE;
                default: st <= MRG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rule_prefetch.sv
// Top of the rule prefetcher.
// It latches the rule count when a pass is accepted and derives the slot count and the early-fetch slot count.
// It instantiates one prefetch unit per memory port and the merge stage.
// Assumption: the next count keeps at least as many slots as were fetched early.
module rule_prefetch #(
    parameter int                NUM_PORTS  = 8,
    parameter int                BEAT_W     = 128,
    parameter int                BEATS      = 8,
    parameter int                ADDR_W     = 32,
    parameter int                CNT_W      = 21,
    parameter int                FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pass_start,
    input  logic [CNT_W-1:0]            rule_count,
    output logic                        pass_active,
    output logic [NUM_PORTS-1:0]        mem_req_valid,
    input  logic [NUM_PORTS-1:0]        mem_req_ready,
    output logic [NUM_PORTS*ADDR_W-1:0] mem_req_addr,
    input  logic [NUM_PORTS-1:0]        mem_rsp_valid,
    input  logic [NUM_PORTS*BEAT_W-1:0] mem_rsp_data,
    output logic                        rule_valid,
    input  logic                        rule_ready,
    output logic [BEAT_W*BEATS/2-1:0]   rule_data,
    output logic [CNT_W-1:0]            rule_idx,
    output logic                        rule_last
);
    localparam int RULE_W = BEAT_W * BEATS / 2;

    logic                        pass_go;
    logic [CNT_W:0]              slots_new;
    logic [CNT_W-1:0]            count_q;
    logic [CNT_W-1:0]            slots_q;
    logic [CNT_W-1:0]            pf_q;
    logic [NUM_PORTS-1:0]        head_valid;
    logic [NUM_PORTS*RULE_W-1:0] head_rule;
    logic [NUM_PORTS-1:0]        pop;

    // Accept a pass only when idle, and work out its slot count.
    always_comb begin
        pass_go   = pass_start && !pass_active;
        slots_new = ({1'b0, rule_count} + 1'b1) >> 1;
    end

    // Latch the count, the slot count and the early-fetch limit for the pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            slots_q <= '0;
            pf_q    <= '0;
        end else if (pass_go) begin
            count_q <= rule_count;
            slots_q <= slots_new[CNT_W-1:0];
            pf_q    <= slots_new[CNT_W-1:0] >> 2;
        end
    end

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_unit
        rpf_unit #(
            .UNIT_ID   (k),
            .NUM_PORTS (NUM_PORTS),
            .BEAT_W    (BEAT_W),
            .BEATS     (BEATS),
            .ADDR_W    (ADDR_W),
            .CNT_W     (CNT_W),
            .FIFO_DEPTH(FIFO_DEPTH),
            .BASE_ADDR (BASE_ADDR)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .pass_go   (pass_go),
            .slots_cur (slots_q),
            .slots_pf  (pf_q),
            .req_valid (mem_req_valid[k]),
            .req_ready (mem_req_ready[k]),
            .req_addr  (mem_req_addr[k*ADDR_W +: ADDR_W]),
            .rsp_valid (mem_rsp_valid[k]),
            .rsp_data  (mem_rsp_data[k*BEAT_W +: BEAT_W]),
            .pop       (pop[k]),
            .head_valid(head_valid[k]),
            .head_rule (head_rule[k*RULE_W +: RULE_W])
        );
    end

    rpf_merge #(
        .NUM_PORTS(NUM_PORTS),
        .RULE_W   (RULE_W),
        .CNT_W    (CNT_W)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_go   (pass_go),
        .cnt       (count_q),
        .head_valid(head_valid),
        .head_rule (head_rule),
        .pop       (pop),
        .out_valid (rule_valid),
        .out_ready (rule_ready),
        .out_rule  (rule_data),
        .out_idx   (rule_idx),
        .out_last  (rule_last),
        .active    (pass_active)
    );
endmodule

// File: rtl/rule_prefetch_chk.sv
// Property checker bound to rule_prefetch. It watches the ports and the latched early-fetch limit.
module rule_prefetch_chk #(
    parameter int NUM_PORTS = 8,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 21,
    parameter int RULE_W    = 512
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        pass_start,
    input logic [CNT_W-1:0]            rule_count,
    input logic                        pass_active,
    input logic [NUM_PORTS-1:0]        mem_req_valid,
    input logic [NUM_PORTS-1:0]        mem_req_ready,
    input logic [NUM_PORTS*ADDR_W-1:0] mem_req_addr,
    input logic                        rule_valid,
    input logic                        rule_ready,
    input logic [RULE_W-1:0]           rule_data,
    input logic                        rule_last,
    input logic [CNT_W-1:0]            pf_q
);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rule_valid && !rule_ready |=> rule_valid && $stable(rule_data));

    // R6
    after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rule_valid && rule_ready && rule_last |=> !rule_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_active |-> !rule_valid);

    // R8
    shrink_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start && !pass_active |-> ((({1'b0, rule_count} + 1'b1) >> 1) >= {1'b0, pf_q}));

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        // R9
        req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req_valid[k] && !mem_req_ready[k] |=>
                mem_req_valid[k] && $stable(mem_req_addr[k*ADDR_W +: ADDR_W]));
    end
endmodule

bind rule_prefetch rule_prefetch_chk #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .RULE_W   (RULE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pass_start   (pass_start),
    .rule_count   (rule_count),
    .pass_active  (pass_active),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .rule_valid   (rule_valid),
    .rule_ready   (rule_ready),
    .rule_data    (rule_data),
    .rule_last    (rule_last),
    .pf_q         (pf_q)
);

// File: tb/rule_prefetch_bench.sv
// Bench for rule_prefetch. A behavioural memory model and stream model are compared on every clock.
module rule_prefetch_bench;
    localparam int NP = 8;
    localparam int BW = 128;
    localparam int AW = 32;
    localparam int CW = 21;
    localparam int DEPTH = 4;
    localparam int RW = 512;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pass_start = 1'b0;
    logic [CW-1:0]    rule_count = '0;
    logic             pass_active;
    logic [NP-1:0]    mem_req_valid;
    logic [NP-1:0]    mem_req_ready = '0;
    logic [NP*AW-1:0] mem_req_addr;
    logic [NP-1:0]    mem_rsp_valid = '0;
    logic [NP*BW-1:0] mem_rsp_data = '0;
    logic             rule_valid;
    logic             rule_ready = 1'b0;
    logic [RW-1:0]    rule_data;
    logic [CW-1:0]    rule_idx;
    logic             rule_last;

    always #10 clk = ~clk;

    rule_prefetch u_rule_prefetch (
        .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .rule_count(rule_count),
        .pass_active(pass_active), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rule_valid(rule_valid), .rule_ready(rule_ready), .rule_data(rule_data),
        .rule_idx(rule_idx), .rule_last(rule_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Record one check and print a failure line when it does not hold.
    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // Beat b of the response at byte address a.
    function automatic logic [BW-1:0] beat_of(input logic [31:0] a, input int b);
        return {a, 32'(b), ~a, a + 32'(b) * 32'h0101_0101};
    endfunction

    // Expected rule r: half (r&1) of slot r/2, built from beats 4h..4h+3 (R4).
    function automatic logic [RW-1:0] rule_of(input int r);
        logic [RW-1:0] v;
        for (int i = 0; i < 4; i++) v[128*i +: 128] = beat_of(32'((r >> 1) * 128), 4 * (r & 1) + i);
        return v;
    endfunction

    int unsigned qa[NP][$];
    longint      qt[NP][$];
    int          bt[NP];
    int          issued[NP];
    int          consumed[NP];
    longint      cyc = 0;
    int          issued_total = 0;
    int          exp_cum = 0;
    int          sum_s = 0;
    int          exp_cnt = 0;
    int          exp_r = 0;
    int          rdy_mode = 0;
    int          stall_left = 0;
    bit          just_started = 0;
    bit          hold_prev = 0;
    logic [RW-1:0] held;

    // Memory model and stream model, evaluated once per cycle away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (!rst_n || done) begin
            mem_req_ready = '0;
            mem_rsp_valid = '0;
        end else begin
            cyc++;
            // R2: pass_active rises the cycle after an accepted start
            if (just_started) chk(pass_active, $sformatf("R2 pass_active after start act=%0b exp=1", pass_active));
            just_started = 0;
            if (pass_start && !pass_active) begin
                // R7: cumulative requests at a pass start = all earlier slots plus the early slots
                chk(issued_total == exp_cum,
                    $sformatf("R7 requests issued before pass start act=%0d exp=%0d", issued_total, exp_cum));
                exp_cnt = int'(rule_count);
                exp_r = 0;
                sum_s += (exp_cnt + 1) / 2;
                exp_cum = sum_s + ((exp_cnt + 1) / 2) / 4;
                just_started = 1;
                stall_left = (rdy_mode == 2) ? 150 : 0;
            end
            // output handshake
            if (stall_left > 0) begin
                rule_ready = 1'b0;
                stall_left--;
            end else if (rdy_mode == 0) rule_ready = 1'b1;
            else rule_ready = ($urandom_range(0, 2) != 0);
            // R9: held rule stays
            if (hold_prev)
                chk(rule_valid && rule_data == held, $sformatf("R9 rule held under stall act_valid=%0b exp=1", rule_valid));
            if (rule_valid) begin
                if (exp_r >= exp_cnt) begin
                    // R6: nothing beyond the last rule
                    chk(0, $sformatf("R6 extra rule delivered act_idx=%0d exp=none (count %0d)", rule_idx, exp_cnt));
                end else begin
                    // R4 R5: contents, index, last flag
                    chk(rule_data == rule_of(exp_r) && int'(rule_idx) == exp_r && rule_last == (exp_r == exp_cnt - 1),
                        $sformatf("R4 R5 rule act_idx=%0d last=%0b data_ok=%0b exp_idx=%0d last=%0b",
                                  rule_idx, rule_last, rule_data == rule_of(exp_r), exp_r, exp_r == exp_cnt - 1));
                    if (rule_ready) begin
                        if ((exp_r & 1) == 1 || exp_r == exp_cnt - 1) consumed[(exp_r >> 1) % NP]++;
                        exp_r++;
                    end
                end
            end
            hold_prev = rule_valid && !rule_ready;
            held = rule_data;
            // requests
            for (int k = 0; k < NP; k++) begin
                mem_req_ready[k] = ($urandom_range(0, 3) != 0);
                if (mem_req_valid[k] && mem_req_ready[k]) begin
                    int unsigned a;
                    a = mem_req_addr[k*AW +: AW];
                    // R3: interleave and alignment
                    chk(a % 128 == 0 && (a / 128) % NP == k,
                        $sformatf("R3 request address port %0d act=0x%0h exp slot%%8=%0d, 128-aligned", k, a, k));
                    qa[k].push_back(a);
                    qt[k].push_back(cyc + 2);
                    issued[k]++;
                    issued_total++;
                end
            end
            // responses
            for (int k = 0; k < NP; k++) begin
                mem_rsp_valid[k] = 1'b0;
                if (qa[k].size() > 0 && qt[k][0] <= cyc && $urandom_range(0, 3) != 0) begin
                    mem_rsp_valid[k] = 1'b1;
                    mem_rsp_data[k*BW +: BW] = beat_of(qa[k][0], bt[k]);
                    bt[k]++;
                    if (bt[k] == 8) begin
                        bt[k] = 0;
                        void'(qa[k].pop_front());
                        void'(qt[k].pop_front());
                    end
                end
                // R10: per-port outstanding plus buffered within the buffer depth
                chk(issued[k] - consumed[k] <= DEPTH,
                    $sformatf("R10 port %0d in flight+buffered act=%0d exp<=%0d", k, issued[k] - consumed[k], DEPTH));
            end
        end
    end

    // Run one pass: let early fetch settle, start it, optionally try a start that must be ignored, then wait.
    task automatic run_pass(input int count, input int mode, input bit poke, input string tag);
        while (pass_active) @(negedge clk);
        repeat (60) @(negedge clk);
        rdy_mode = mode;
        rule_count = CW'(count);
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            rule_count = CW'(3);
            pass_start = 1'b1; // R2: must be ignored while active
            @(negedge clk);
            pass_start = 1'b0;
        end
        @(negedge clk);
        while (pass_active) @(negedge clk);
        #2;
        chk(exp_r == count, $sformatf("%s rules delivered in pass act=%0d exp=%0d", tag, exp_r, count));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs low while reset is held
        chk(!pass_active && !rule_valid && mem_req_valid == '0,
            $sformatf("R1 in reset act act=%0b val=%0b req=%0h exp=0", pass_active, rule_valid, mem_req_valid));
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!pass_active && !rule_valid && mem_req_valid == '0,
            $sformatf("R1 after reset act=%0b val=%0b req=%0h exp=0", pass_active, rule_valid, mem_req_valid));
        run_pass(37, 0, 0, "R5");
        run_pass(100, 1, 1, "R2");
        run_pass(24, 2, 0, "R8");   // shrinks exactly to the early-fetch limit
        run_pass(5, 1, 0, "R8");    // limit again, odd count: surplus early rule dropped (R6)
        run_pass(8, 0, 0, "R5");
        run_pass(1, 0, 0, "R6");    // single rule, limit from the pass of 8
        run_pass(200, 1, 0, "R5");
        run_pass(77, 2, 0, "R10");
        repeat (80) @(negedge clk);
        #2;
        chk(issued_total == exp_cum, $sformatf("R7 early requests after last pass act=%0d exp=%0d", issued_total, exp_cum));
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule